// File: doc/BRIEF.md
# Byte-Lane Packing Data Buffer

This block is the data port of a serial bus controller. It keeps a small holding register of bytes that serves both directions. The host loads outgoing bytes with full-width port writes, or with a single-byte write for a trailing odd byte. The transfer engine takes those bytes one at a time, most significant lane first. Bytes coming back from the engine fill the lanes from the bottom up, and the host drains them with full-width port reads.

A byte-order control input sets which byte of a host word travels first on the bus. The same input sets which received byte appears in the upper half of a read word. The block does not touch the status register itself. It emits single-cycle set and clear pulses so that the status logic can update receive-ready, transmit-ready, access-ready, underflow, overrun, master mode and the partial-read flag. It also emits a pulse that tells the engine to carry on after each read.

All state changes on the rising clock edge. The read data, both byte counts and every event pulse are registered and show the effect of a strobe in the cycle after the strobe. A host access takes priority over the engine: in a cycle that carries a host write or read, the engine's receive and take strobes are ignored.

Top module: `byte_pack_buffer`

## Requirements
- R1: After reset both byte counts are 0, the read data is 0, the offered transmit byte is 0 and every event pulse is low.
- R2: An accepted full-width write shifts the buffer up by two lanes and increases the transmit count by 2. With msb_first=1, data bits [15:8] go to lane 1 and bits [7:0] to lane 0. With msb_first=0, the two bytes are swapped.
- R3: An accepted single-byte write (host_wr_byte=1) shifts the buffer up by one lane, puts data bits [7:0] into lane 0 and increases the transmit count by 1.
- R4: A write of either width is refused when the transmit count is above 2 (BUF_BYTES-PORT_BYTES). A refused write leaves the counts and lanes unchanged and raises no pulse.
- R5: Every accepted write pulses ev_tx_underflow_clr. It also pulses ev_tx_ready_clr when the new transmit count is above 2.
- R6: eng_tx_byte shows lane (transmit count - 1), or 0 when the count is 0. A take strobe decrements the count. A take strobe at count 0 is ignored.
- R7: A received byte is written into the lane indexed by the receive count, and the count then increments. A received byte at count 4 is ignored.
- R8: A read returns lanes 1 and 0. With msb_first=1, lane 0 is in bits [15:8] and lane 1 in bits [7:0]. With msb_first=0, lane 1 is in bits [15:8] and lane 0 in bits [7:0]. A read at count above 2 shifts the buffer down by two lanes and subtracts 2 from the count. A read at count 2 empties the buffer.
- R9: A read at receive count 1 pulses ev_partial_set and empties the buffer.
- R10: A read that leaves the receive count at 0 pulses ev_rx_ready_clr. If is_master=1 and is_tx=0, that read also pulses ev_access_ready_set and ev_master_clr.
- R11: Every read pulses ev_rx_overrun_clr and ev_engine_kick.
- R12: A read at receive count 0 returns 0 and leaves both counts unchanged.
- R13: In a cycle with a host write or read, eng_rx_valid and eng_tx_take have no effect. When host_wr and host_rd are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wr_byte | input | 1 | 1: single-byte write, 0: full-width write |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe for the data port |
| host_rdata | output | 16 | Data returned by the last read |
| msb_first | input | 1 | Lane order selection |
| is_master | input | 1 | Controller is in master mode |
| is_tx | input | 1 | Controller is transmitting |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| tx_count | output | 3 | Bytes pending for transmit |
| rx_count | output | 3 | Received bytes held |
| ev_partial_set | output | 1 | Pulse: lone-byte read occurred |
| ev_rx_ready_clr | output | 1 | Pulse: clear receive-ready |
| ev_access_ready_set | output | 1 | Pulse: set access-ready |
| ev_master_clr | output | 1 | Pulse: clear master mode |
| ev_tx_underflow_clr | output | 1 | Pulse: clear transmit underflow |
| ev_tx_ready_clr | output | 1 | Pulse: clear transmit-ready |
| ev_rx_overrun_clr | output | 1 | Pulse: clear receive overrun |
| ev_engine_kick | output | 1 | Pulse: engine may continue |

## Verification
The bench builds the block with its defaults: 8-bit lanes, a 4-lane buffer and a 2-lane port. With these values the refusal threshold of two pending bytes is reached after one full and one single-byte write. A three-byte queue then shows the transmit-ready clear and the refused fourth write. Four received bytes fill the buffer, so the ignored fifth byte, the shifting read and the emptying read can all be reached in one run. Both lane orders are exercised, on writes and on reads.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

   typedef struct packed {
      logic partial_set;
      logic rx_ready_clr;
      logic access_ready_set;
      logic master_clr;
      logic tx_underflow_clr;
      logic tx_ready_clr;
      logic rx_overrun_clr;
      logic engine_kick;
   } dbuf_evt_t;

endpackage

// File: rtl/dbuf_lane_order.sv
module dbuf_lane_order #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   localparam int WORD_W = BYTE_W * LANES
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              reverse,
   output logic [WORD_W-1:0] word_out
);

   logic [WORD_W-1:0] flipped;

   generate
      if (LANES < 1) begin : g_bad
         $error("dbuf_lane_order: LANES must be at least 1");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign flipped[i*BYTE_W +: BYTE_W] = word_in[(LANES-1-i)*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign word_out = reverse ? flipped : word_in;

endmodule

// File: rtl/dbuf_tx_pick.sv
module dbuf_tx_pick #(
   parameter int BYTE_W    = 8,
   parameter int BUF_BYTES = 4,
   localparam int BUF_W = BYTE_W * BUF_BYTES,
   localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
   input  logic [BUF_W-1:0]  lanes,
   input  logic [CNT_W-1:0]  count,
   output logic [BYTE_W-1:0] pick
);

   always_comb begin
      pick = '0;
      for (int i = 0; i < BUF_BYTES; i++) begin
         if (count == CNT_W'(i + 1)) pick = lanes[i*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/dbuf_event_reg.sv
module dbuf_event_reg
   import dbuf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  dbuf_evt_t evt_d,
   output dbuf_evt_t evt_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= evt_d;
   end

endmodule

// File: rtl/byte_pack_buffer.sv
module byte_pack_buffer
   import dbuf_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int BUF_BYTES  = 4,
   parameter int PORT_BYTES = 2,
   localparam int BUF_W  = BYTE_W * BUF_BYTES,
   localparam int PORT_W = BYTE_W * PORT_BYTES,
   localparam int CNT_W  = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_wr_byte,
   input  logic [PORT_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [PORT_W-1:0] host_rdata,
   input  logic              msb_first,
   input  logic              is_master,
   input  logic              is_tx,
   input  logic              eng_rx_valid,
   input  logic [BYTE_W-1:0] eng_rx_byte,
   input  logic              eng_tx_take,
   output logic [BYTE_W-1:0] eng_tx_byte,
   output logic [CNT_W-1:0]  tx_count,
   output logic [CNT_W-1:0]  rx_count,
   output logic              ev_partial_set,
   output logic              ev_rx_ready_clr,
   output logic              ev_access_ready_set,
   output logic              ev_master_clr,
   output logic              ev_tx_underflow_clr,
   output logic              ev_tx_ready_clr,
   output logic              ev_rx_overrun_clr,
   output logic              ev_engine_kick
);

   localparam logic [CNT_W-1:0] TX_LIMIT = CNT_W'(BUF_BYTES - PORT_BYTES);
   localparam logic [CNT_W-1:0] CNT_PORT = CNT_W'(PORT_BYTES);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (PORT_BYTES < 2) begin : g_port_chk
         $error("byte_pack_buffer: PORT_BYTES must be at least 2");
      end
      if (BUF_BYTES < 2 * PORT_BYTES) begin : g_buf_chk
         $error("byte_pack_buffer: BUF_BYTES must hold two port words");
      end
   endgenerate

   logic [BUF_W-1:0]  lanes_q, lanes_d;
   logic [CNT_W-1:0]  tx_q, tx_d, rx_q, rx_d;
   logic [PORT_W-1:0] rdata_q, rdata_d;
   logic [PORT_W-1:0] wr_word, rd_word;
   dbuf_evt_t         evt_d, evt_q;

   // Host access outranks the engine; a write outranks a read.
   logic wr_go, rd_go, host_busy, wr_ok;
   assign wr_go     = host_wr;
   assign rd_go     = host_rd & ~host_wr;
   assign host_busy = host_wr | host_rd;
   assign wr_ok     = wr_go && (tx_q <= TX_LIMIT);

   dbuf_lane_order #(.BYTE_W(BYTE_W), .LANES(PORT_BYTES)) u_wr_order (
      .word_in (host_wdata),
      .reverse (~msb_first),
      .word_out(wr_word)
   );

   dbuf_lane_order #(.BYTE_W(BYTE_W), .LANES(PORT_BYTES)) u_rd_order (
      .word_in (lanes_q[PORT_W-1:0]),
      .reverse (msb_first),
      .word_out(rd_word)
   );

   dbuf_tx_pick #(.BYTE_W(BYTE_W), .BUF_BYTES(BUF_BYTES)) u_tx_pick (
      .lanes(lanes_q),
      .count(tx_q),
      .pick (eng_tx_byte)
   );

   always_comb begin
      lanes_d = lanes_q;
      tx_d    = tx_q;
      rx_d    = rx_q;
      rdata_d = rdata_q;
      evt_d   = '0;
      if (wr_ok) begin
         if (host_wr_byte) begin
            lanes_d = {lanes_q[BUF_W-BYTE_W-1:0], host_wdata[BYTE_W-1:0]};
            tx_d    = tx_q + CNT_ONE;
         end else begin
            lanes_d = {lanes_q[BUF_W-PORT_W-1:0], wr_word};
            tx_d    = tx_q + CNT_PORT;
         end
         evt_d.tx_underflow_clr = 1'b1;
         evt_d.tx_ready_clr     = (tx_d > TX_LIMIT);
      end else if (rd_go) begin
         evt_d.rx_overrun_clr = 1'b1;
         evt_d.engine_kick    = 1'b1;
         if (rx_q == '0) begin
            rdata_d = '0;
         end else begin
            rdata_d = rd_word;
            if (rx_q < CNT_PORT) begin
               evt_d.partial_set = 1'b1;
               rx_d = '0;
            end else if (rx_q > CNT_PORT) begin
               lanes_d = lanes_q >> PORT_W;
               rx_d    = rx_q - CNT_PORT;
            end else begin
               rx_d = '0;
            end
         end
         if (rx_d == '0) begin
            evt_d.rx_ready_clr = 1'b1;
            if (is_master && !is_tx) begin
               evt_d.access_ready_set = 1'b1;
               evt_d.master_clr       = 1'b1;
            end
         end
      end else if (!host_busy) begin
         if (eng_rx_valid && rx_q < CNT_FULL) begin
            for (int i = 0; i < BUF_BYTES; i++) begin
               if (rx_q == CNT_W'(i)) lanes_d[i*BYTE_W +: BYTE_W] = eng_rx_byte;
            end
            rx_d = rx_q + CNT_ONE;
         end
         if (eng_tx_take && tx_q != '0) tx_d = tx_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lanes_q <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rdata_q <= '0;
      end else begin
         lanes_q <= lanes_d;
         tx_q    <= tx_d;
         rx_q    <= rx_d;
         rdata_q <= rdata_d;
      end
   end

   dbuf_event_reg u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .evt_d(evt_d),
      .evt_q(evt_q)
   );

   assign host_rdata          = rdata_q;
   assign tx_count            = tx_q;
   assign rx_count            = rx_q;
   assign ev_partial_set      = evt_q.partial_set;
   assign ev_rx_ready_clr     = evt_q.rx_ready_clr;
   assign ev_access_ready_set = evt_q.access_ready_set;
   assign ev_master_clr       = evt_q.master_clr;
   assign ev_tx_underflow_clr = evt_q.tx_underflow_clr;
   assign ev_tx_ready_clr     = evt_q.tx_ready_clr;
   assign ev_rx_overrun_clr   = evt_q.rx_overrun_clr;
   assign ev_engine_kick      = evt_q.engine_kick;

   // R3: a single-byte write adds exactly one pending byte
   a_r3_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_wr_byte && tx_count <= TX_LIMIT) |=> (tx_count == $past(tx_count) + CNT_ONE));

   // R4: a refused write changes nothing and raises no pulse
   a_r4_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && tx_count > TX_LIMIT) |=> ($stable(tx_count) && !ev_tx_underflow_clr));

   // R5: accepted write clears underflow
   a_r5_underflow_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && tx_count <= TX_LIMIT) |=> ev_tx_underflow_clr);

   // R7: a full receive side ignores more bytes
   a_r7_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && !host_rd && eng_rx_valid && rx_count == CNT_FULL) |=> (rx_count == CNT_FULL));

   // R9: lone-byte read flags and empties
   a_r9_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && rx_count == CNT_ONE) |=> (ev_partial_set && rx_count == '0));

   // R11: every read clears overrun and lets the engine go on
   a_r11_read_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> (ev_rx_overrun_clr && ev_engine_kick));

   // R12: empty read returns zero, counts unchanged
   a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && rx_count == '0) |=> (host_rdata == '0 && rx_count == '0 && $stable(tx_count)));

   // R13: engine strobes are ignored during a host access
   a_r13_host_first: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> $stable(tx_count));

endmodule

// File: tb/tb_byte_pack_buffer.sv
module tb_byte_pack_buffer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 0, host_wr_byte = 0, host_rd = 0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        msb_first = 0, is_master = 0, is_tx = 0;
   logic        eng_rx_valid = 0, eng_tx_take = 0;
   logic [7:0]  eng_rx_byte = '0;
   logic [7:0]  eng_tx_byte;
   logic [2:0]  tx_count, rx_count;
   logic        ev_partial_set, ev_rx_ready_clr, ev_access_ready_set, ev_master_clr;
   logic        ev_tx_underflow_clr, ev_tx_ready_clr, ev_rx_overrun_clr, ev_engine_kick;

   int total = 0, failed = 0;
   bit done = 0;

   always #4 clk = ~clk;

   byte_pack_buffer dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .msb_first(msb_first), .is_master(is_master), .is_tx(is_tx),
      .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
      .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte),
      .tx_count(tx_count), .rx_count(rx_count),
      .ev_partial_set(ev_partial_set), .ev_rx_ready_clr(ev_rx_ready_clr),
      .ev_access_ready_set(ev_access_ready_set), .ev_master_clr(ev_master_clr),
      .ev_tx_underflow_clr(ev_tx_underflow_clr), .ev_tx_ready_clr(ev_tx_ready_clr),
      .ev_rx_overrun_clr(ev_rx_overrun_clr), .ev_engine_kick(ev_engine_kick)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Each strobe is raised at a falling edge, held over one rising edge,
   // and dropped shortly after it; results are then stable for sampling.
   task automatic host_write(logic [15:0] d, logic one_byte);
      @(negedge clk);
      host_wr = 1; host_wr_byte = one_byte; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 0; host_wr_byte = 0;
   endtask

   task automatic host_read();
      @(negedge clk);
      host_rd = 1;
      @(posedge clk); #1;
      host_rd = 0;
   endtask

   task automatic rx_push(logic [7:0] b);
      @(negedge clk);
      eng_rx_valid = 1; eng_rx_byte = b;
      @(posedge clk); #1;
      eng_rx_valid = 0;
   endtask

   task automatic tx_pop();
      @(negedge clk);
      eng_tx_take = 1;
      @(posedge clk); #1;
      eng_tx_take = 0;
   endtask

   task automatic t_reset();
      check("R1 tx_count", tx_count, 0);
      check("R1 rx_count", rx_count, 0);
      check("R1 rdata", host_rdata, 0);
      check("R1 tx_byte", eng_tx_byte, 0);
      check("R1 pulses", {ev_partial_set, ev_rx_ready_clr, ev_access_ready_set, ev_master_clr,
                          ev_tx_underflow_clr, ev_tx_ready_clr, ev_rx_overrun_clr, ev_engine_kick}, 0);
   endtask

   task automatic t_word_msb_first();
      msb_first = 1;
      host_write(16'hA1B2, 0);
      check("R2 count", tx_count, 2);
      check("R2 first lane", eng_tx_byte, 8'hA1);
      check("R5 underflow clr", ev_tx_underflow_clr, 1);
      check("R5 no ready clr", ev_tx_ready_clr, 0);
      tx_pop();
      check("R6 count", tx_count, 1);
      check("R6 next byte", eng_tx_byte, 8'hB2);
      tx_pop();
      check("R6 empty byte", eng_tx_byte, 0);
      tx_pop();
      check("R6 pop at zero", tx_count, 0);
   endtask

   task automatic t_swap_and_byte();
      msb_first = 0;
      host_write(16'hA1B2, 0);
      check("R2 swapped lane", eng_tx_byte, 8'hB2);
      host_write(16'h995C, 1);
      check("R3 count", tx_count, 3);
      check("R3 lane order", eng_tx_byte, 8'hB2);
      check("R5 ready clr", ev_tx_ready_clr, 1);
      host_write(16'h1234, 0);
      check("R4 count kept", tx_count, 3);
      check("R4 no pulse", ev_tx_underflow_clr, 0);
      check("R4 lane kept", eng_tx_byte, 8'hB2);
      tx_pop();
      check("R2 second byte", eng_tx_byte, 8'hA1);
      tx_pop();
      check("R3 inserted byte", eng_tx_byte, 8'h5C);
      tx_pop();
      check("R6 drained", tx_count, 0);
   endtask

   task automatic t_receive_reads();
      is_master = 1; is_tx = 0;
      rx_push(8'h11); rx_push(8'h22); rx_push(8'h33); rx_push(8'h44);
      check("R7 count", rx_count, 4);
      rx_push(8'h55);
      check("R7 full ignored", rx_count, 4);
      msb_first = 1;
      host_read();
      check("R8 msb_first word", host_rdata, 16'h1122);
      check("R8 count after shift", rx_count, 2);
      check("R10 not empty", ev_rx_ready_clr, 0);
      check("R11 overrun clr", ev_rx_overrun_clr, 1);
      check("R11 kick", ev_engine_kick, 1);
      msb_first = 0;
      host_read();
      check("R8 plain word", host_rdata, 16'h4433);
      check("R8 emptied", rx_count, 0);
      check("R10 rx ready clr", ev_rx_ready_clr, 1);
      check("R10 access ready", ev_access_ready_set, 1);
      check("R10 master clr", ev_master_clr, 1);
   endtask

   task automatic t_lone_byte();
      is_tx = 1;
      rx_push(8'h77);
      host_read();
      check("R9 word", host_rdata, 16'h4477);
      check("R9 partial", ev_partial_set, 1);
      check("R9 count", rx_count, 0);
      check("R10 rx ready clr", ev_rx_ready_clr, 1);
      check("R10 no access ready when tx", ev_access_ready_set, 0);
   endtask

   task automatic t_empty_read();
      host_read();
      check("R12 data", host_rdata, 0);
      check("R12 rx count", rx_count, 0);
      check("R12 no partial", ev_partial_set, 0);
      check("R11 overrun clr", ev_rx_overrun_clr, 1);
   endtask

   task automatic t_priority();
      @(negedge clk);
      host_wr = 1; host_wdata = 16'h0102; eng_rx_valid = 1; eng_rx_byte = 8'hEE;
      @(posedge clk); #1;
      host_wr = 0; eng_rx_valid = 0;
      check("R13 rx ignored", rx_count, 0);
      check("R13 write done", tx_count, 2);
      @(negedge clk);
      host_rd = 1; eng_tx_take = 1;
      @(posedge clk); #1;
      host_rd = 0; eng_tx_take = 0;
      check("R13 take ignored", tx_count, 2);
      @(negedge clk);
      host_wr = 1; host_rd = 1; host_wdata = 16'h0304; eng_tx_take = 0;
      @(posedge clk); #1;
      host_wr = 0; host_rd = 0;
      check("R13 write wins", tx_count, 4);
      check("R13 read skipped", ev_rx_overrun_clr, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk) rst_n = 1;
      t_word_msb_first();
      t_swap_and_byte();
      t_receive_reads();
      t_lone_byte();
      t_empty_read();
      t_priority();
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

endmodule